// File: doc/BRIEF.md
# Sampled Overcurrent Trip Sequencer

This block is the digital side of the current limit for a synchronous buck converter. One clock tick is one timing step. The block measures how long the PWM high-side request stays asserted in each switching period. From that length it keeps a sample point at three quarters of the on-time, rounded down. In the following period it reads the current-sense comparator once, at exactly that stored point, and declares a trip if the comparator is high.

After a trip, the block lets the period in progress finish. At the next rising edge of the request it forces a high-side pulse half as long as the tripped on-time. It then holds both switches off for four soft-start periods. At the end of that wait it issues a single-cycle restart request and enters soft-start again.

During soft-start the block raises a select bit that doubles the comparator threshold. The bit clears once the soft-start-done flag is seen. The comparator, the threshold DAC and the gate drivers sit outside this block.

Top module: `oc_trip_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released: hs_en=0, ls_en=0, thr_double=1, ss_restart=0, trip_flag=0. After reset or a restart, ls_en stays 0 until the first clock with hs_req=1.
- R2: In normal operation hs_en equals hs_req and ls_en equals the inverse of hs_req (once primed). hs_en and ls_en are never 1 in the same clock.
- R3: Each clock with hs_req=1 counts as one step of on-time. For a measured on-time of N steps, the sample point for the next period is floor(3N/4). oc_cmp (1 = sense above reference) is looked at only in the clock that is the sample-point-th high clock of that next pulse.
- R4: When oc_cmp=1 in the sampling clock, trip_flag rises one clock later. It then stays 1 until the restart.
- R5: No sample is taken while the stored point is zero, which is the value after reset and after a restart. No sample is taken in a period whose on-time ends before the stored point.
- R6: After a trip, hs_en and ls_en keep following hs_req until the next rising edge of hs_req.
- R7: From that rising edge, hs_en is held at 1 for floor(Ntrip/2) clocks, counting the edge clock, whatever hs_req does. Ntrip is the on-time of the tripped period.
- R8: After the extra on-time, hs_en=0 and ls_en=0, and hs_req is ignored.
- R9: thr_double is 1 during soft-start. It goes to 0 one clock after ss_done=1 is seen while no trip is in progress.
- R10: The both-off wait lasts exactly 4*SS_TICKS clocks. ss_restart is 1 only in the last of those clocks.
- R11: In the clock after ss_restart, soft-start begins again with thr_double=1 and trip_flag=0, and the stored sample point is cleared.
- R12: The on-time count saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one on-time step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hs_req | input | 1 | PWM high-side request |
| oc_cmp | input | 1 | Current-sense comparator, 1 when sense exceeds the reference |
| ss_done | input | 1 | Soft-start complete flag |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| thr_double | output | 1 | Selects the doubled trip threshold |
| ss_restart | output | 1 | One-clock request to start a new soft-start |
| trip_flag | output | 1 | Overcurrent trip latched |

## Verification
The bench builds the block with CNT_W=6 and SS_TICKS=8. With those values a 70-step pulse saturates the on-time counter, which lets the bench check that the next sample lands at step 47 rather than at a wrapped value. The whole four-period wait takes only 32 clocks, so the bench can count it edge to edge. With small pulse widths it can pick sample points that tell the previous period's point apart from the current period's point.

// File: rtl/octrip_pkg.sv
package octrip_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_FINISH = 2'd1,
    ST_EXTRA  = 2'd2,
    ST_OFF    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/octrip_ontime.sv
// Measures high-side on-time, holds the 3/4 sample point for the next period.
module octrip_ontime #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             hs_req,
  output logic             rise,
  output logic             samp_hit,
  output logic [CNT_W-1:0] half_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] samp_q, samp_d;
  logic [CNT_W-1:0] ton_q, ton_d;
  logic [CNT_W+1:0] triple;
  logic             fall;
  logic             cnt_en, samp_en;

  always_comb begin
    rise   = run && hs_req && (cnt_q == '0);
    fall   = run && !hs_req && (cnt_q != '0);
    triple = ({2'b00, cnt_q} << 1) + {2'b00, cnt_q};

    cnt_en = 1'b1;
    if (!run || !hs_req)      cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;

    samp_en = clr || fall;
    if (clr) begin
      samp_d = '0;
      ton_d  = '0;
    end else begin
      samp_d = triple[CNT_W+1:2];
      ton_d  = cnt_q;
    end

    samp_hit = run && hs_req && (samp_q != '0) &&
               (({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) == {1'b0, samp_q});
    half_len = ton_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      samp_q <= '0;
      ton_q  <= '0;
    end else begin
      if (cnt_en)  cnt_q <= cnt_d;
      if (samp_en) begin
        samp_q <= samp_d;
        ton_q  <= ton_d;
      end
    end
  end
endmodule

// File: rtl/octrip_seq.sv
// Trip, finish, extra on-time, off wait and restart sequencing.
module octrip_seq
  import octrip_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SS_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_req,
  input  logic             oc_cmp,
  input  logic             ss_done,
  input  logic             rise,
  input  logic             samp_hit,
  input  logic [CNT_W-1:0] half_len,
  output seq_state_t       st,
  output logic             ss_active,
  output logic             trip_flag,
  output logic             primed,
  output logic             restart
);
  localparam int WAIT_LEN = 4 * SS_TICKS;
  localparam int WAIT_W   = (WAIT_LEN > 2) ? $clog2(WAIT_LEN) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LEN - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] ext_q, ext_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic             ssa_q, ssa_d;
  logic             trip_q, trip_d;
  logic             prm_q, prm_d;

  always_comb begin
    st_d    = st_q;
    ext_d   = ext_q;
    wait_d  = '0;
    ssa_d   = ssa_q;
    trip_d  = trip_q;
    prm_d   = prm_q;
    restart = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (hs_req) prm_d = 1'b1;
        if (samp_hit && oc_cmp) begin
          trip_d = 1'b1;
          st_d   = ST_FINISH;
        end else if (ss_done) begin
          ssa_d = 1'b0;
        end
      end
      ST_FINISH: begin
        if (rise) begin
          if (half_len <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
            st_d = ST_OFF;
          end else begin
            st_d  = ST_EXTRA;
            ext_d = half_len - 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        ext_d = ext_q - 1'b1;
        if (ext_q <= {{(CNT_W-1){1'b0}}, 1'b1}) st_d = ST_OFF;
      end
      ST_OFF: begin
        wait_d = wait_q + 1'b1;
        if (wait_q == WAIT_LAST) begin
          restart = 1'b1;
          st_d    = ST_ACTIVE;
          ssa_d   = 1'b1;
          trip_d  = 1'b0;
          prm_d   = 1'b0;
          wait_d  = '0;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACTIVE;
      ext_q  <= '0;
      wait_q <= '0;
      ssa_q  <= 1'b1;
      trip_q <= 1'b0;
      prm_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ext_q  <= ext_d;
      wait_q <= wait_d;
      ssa_q  <= ssa_d;
      trip_q <= trip_d;
      prm_q  <= prm_d;
    end
  end

  assign st        = st_q;
  assign ss_active = ssa_q;
  assign trip_flag = trip_q;
  assign primed    = prm_q;
endmodule

// File: rtl/octrip_gate.sv
// Maps sequencer state and PWM request onto the two switch enables.
module octrip_gate
  import octrip_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  seq_state_t       st,
  input  logic             hs_req,
  input  logic             rise,
  input  logic             primed,
  input  logic [CNT_W-1:0] half_len,
  output logic             hs_en,
  output logic             ls_en
);
  always_comb begin
    hs_en = 1'b0;
    ls_en = 1'b0;
    unique case (st)
      ST_ACTIVE: begin
        hs_en = hs_req;
        ls_en = !hs_req && primed;
      end
      ST_FINISH: begin
        hs_en = hs_req && (!rise || (half_len != '0));
        ls_en = !hs_req && primed;
      end
      ST_EXTRA: hs_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/oc_trip_sequencer.sv
module oc_trip_sequencer
  import octrip_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SS_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic oc_cmp,
  input  logic ss_done,
  output logic hs_en,
  output logic ls_en,
  output logic thr_double,
  output logic ss_restart,
  output logic trip_flag
);
  seq_state_t       st;
  logic             run, rise, samp_hit, primed, restart, ss_active;
  logic [CNT_W-1:0] half_len;

  assign run = (st == ST_ACTIVE) || (st == ST_FINISH);

  octrip_ontime #(.CNT_W(CNT_W)) u_ontime (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (restart),
    .hs_req   (hs_req),
    .rise     (rise),
    .samp_hit (samp_hit),
    .half_len (half_len)
  );

  octrip_seq #(.CNT_W(CNT_W), .SS_TICKS(SS_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_req    (hs_req),
    .oc_cmp    (oc_cmp),
    .ss_done   (ss_done),
    .rise      (rise),
    .samp_hit  (samp_hit),
    .half_len  (half_len),
    .st        (st),
    .ss_active (ss_active),
    .trip_flag (trip_flag),
    .primed    (primed),
    .restart   (restart)
  );

  octrip_gate #(.CNT_W(CNT_W)) u_gate (
    .st       (st),
    .hs_req   (hs_req),
    .rise     (rise),
    .primed   (primed),
    .half_len (half_len),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
  );

  assign thr_double = ss_active;
  assign ss_restart = restart;
endmodule

// File: rtl/octrip_chk.sv
module octrip_chk
  import octrip_pkg::*;
#(
  parameter int SS_TICKS = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_en,
  input logic       ls_en,
  input logic       thr_double,
  input logic       ss_restart,
  input logic       trip_flag,
  input logic       ss_done,
  input seq_state_t st
);
  localparam int WAIT_LEN = 4 * SS_TICKS;
  int off_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           off_len <= 0;
    else if (st == ST_OFF) off_len <= off_len + 1;
    else                  off_len <= 0;
  end

  assert_gates_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));
  assert_trip_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && !ss_restart) |=> trip_flag);
  assert_extra_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXTRA) |-> (hs_en && !ls_en));
  assert_off_both_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |-> (!hs_en && !ls_en));
  assert_thr_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thr_double) |-> $past(ss_done));
  assert_wait_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (off_len == WAIT_LEN - 1));
  assert_restart_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
  assert_restart_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> (thr_double && !trip_flag && st == ST_ACTIVE));
endmodule

bind oc_trip_sequencer octrip_chk #(.SS_TICKS(SS_TICKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hs_en      (hs_en),
  .ls_en      (ls_en),
  .thr_double (thr_double),
  .ss_restart (ss_restart),
  .trip_flag  (trip_flag),
  .ss_done    (ss_done),
  .st         (st)
);

// File: tb/oc_trip_sequencer_test.sv
module oc_trip_sequencer_test;
  localparam int CNT_W    = 6;
  localparam int SS_TICKS = 8;
  localparam int B_HS = 4, B_LS = 3, B_THR = 2, B_RS = 1, B_TRIP = 0;

  logic clk = 1'b0;
  logic rst_n, hs_req, oc_cmp, ss_done;
  logic hs_en, ls_en, thr_double, ss_restart, trip_flag;
  logic [4:0] outs;
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    int    bit_i;
    logic  val;
    string req;
  } item_t;
  item_t sb[$];
  item_t it;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oc_trip_sequencer #(.CNT_W(CNT_W), .SS_TICKS(SS_TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .oc_cmp(oc_cmp), .ss_done(ss_done),
    .hs_en(hs_en), .ls_en(ls_en), .thr_double(thr_double),
    .ss_restart(ss_restart), .trip_flag(trip_flag)
  );

  assign outs = {hs_en, ls_en, thr_double, ss_restart, trip_flag};

  function automatic string bit_name(input int b);
    case (b)
      B_HS:    return "hs_en";
      B_LS:    return "ls_en";
      B_THR:   return "thr_double";
      B_RS:    return "ss_restart";
      default: return "trip_flag";
    endcase
  endfunction

  // Monitor: pops expected items for the current cycle and compares.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      n_chk++;
      if (it.cyc != cyc || outs[it.bit_i] !== it.val) begin
        n_err++;
        $display("FAIL %s: cycle %0d %s actual %b expected %b",
                 it.req, cyc, bit_name(it.bit_i), outs[it.bit_i], it.val);
      end
    end
  end

  task automatic tick(input logic h, input logic c, input logic d);
    @(posedge clk);
    #2;
    hs_req = h;
    oc_cmp = c;
    ss_done = d;
  endtask

  task automatic expect_bit(input int b, input logic v, input string r);
    item_t x;
    x.cyc = cyc;
    x.bit_i = b;
    x.val = v;
    x.req = r;
    sb.push_back(x);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hs_req = 1'b0; oc_cmp = 1'b0; ss_done = 1'b0;
    tick(0, 0, 0);
    tick(0, 0, 0);
    expect_bit(B_HS, 0, "R1"); expect_bit(B_LS, 0, "R1"); expect_bit(B_THR, 1, "R1");
    expect_bit(B_RS, 0, "R1"); expect_bit(B_TRIP, 0, "R1");
    tick(0, 0, 0);
    rst_n = 1'b1;
    tick(0, 0, 0);
    tick(0, 0, 0);
    expect_bit(B_LS, 0, "R1");
    expect_bit(B_THR, 1, "R1");

    // Pulse A: first measurement, no stored point yet, comparator high (R5)
    for (int i = 1; i <= 8; i++) begin
      tick(1, 1, 0);
      expect_bit(B_HS, 1, "R2"); expect_bit(B_LS, 0, "R2");
    end
    for (int i = 1; i <= 8; i++) begin
      tick(0, 1, 0);
      expect_bit(B_HS, 0, "R2"); expect_bit(B_LS, 1, "R2");
      expect_bit(B_TRIP, 0, "R5"); expect_bit(B_THR, 1, "R9");
    end
    // soft-start done
    tick(0, 0, 1);
    expect_bit(B_THR, 1, "R9");
    tick(0, 0, 0);
    expect_bit(B_THR, 0, "R9");

    // Pulse B: 5 steps, shorter than stored point 6 (R5)
    for (int i = 1; i <= 5; i++) tick(1, 1, 0);
    for (int i = 1; i <= 6; i++) begin
      tick(0, 0, 0);
      expect_bit(B_TRIP, 0, "R5");
    end

    // Pulse C: stored point 3 from B; comparator low only at step 3 (R3)
    for (int i = 1; i <= 8; i++) tick(1, (i != 3), 0);
    for (int i = 1; i <= 6; i++) begin
      tick(0, 0, 0);
      expect_bit(B_TRIP, 0, "R3");
    end

    // Pulse D: stored point 6 from C; comparator high only at step 6 (R4)
    for (int i = 1; i <= 10; i++) begin
      tick(1, (i == 6), 0);
      expect_bit(B_HS, 1, "R6");
      if (i == 6) expect_bit(B_TRIP, 0, "R4");
      if (i == 7) expect_bit(B_TRIP, 1, "R4");
    end
    for (int i = 1; i <= 6; i++) begin
      tick(0, 0, 0);
      expect_bit(B_HS, 0, "R6"); expect_bit(B_LS, 1, "R6");
      expect_bit(B_TRIP, 1, "R4");
    end
    // Next rising edge: half of 10 = 5 forced steps, then 32-clock off wait
    for (int i = 1; i <= 40; i++) begin
      tick((i <= 2) || (i >= 20 && i <= 25), 0, 0);
      if (i <= 5) begin
        expect_bit(B_HS, 1, "R7"); expect_bit(B_LS, 0, "R7");
      end else if (i <= 37) begin
        expect_bit(B_HS, 0, "R8"); expect_bit(B_LS, 0, "R8");
        expect_bit(B_RS, (i == 37), "R10");
        expect_bit(B_TRIP, 1, "R4");
      end else if (i == 38) begin
        expect_bit(B_RS, 0, "R10"); expect_bit(B_THR, 1, "R11");
        expect_bit(B_TRIP, 0, "R11"); expect_bit(B_LS, 0, "R1");
      end
    end

    // Pulse G: stored point cleared by restart, comparator high (R11)
    for (int i = 1; i <= 8; i++) tick(1, 1, 0);
    for (int i = 1; i <= 3; i++) begin
      tick(0, 0, 0);
      expect_bit(B_TRIP, 0, "R11");
    end

    // Pulse E: 70 steps saturate at 63 -> point 47 (R12)
    for (int i = 1; i <= 70; i++) tick(1, 0, 0);
    for (int i = 1; i <= 5; i++) tick(0, 0, 0);
    // Pulse F: comparator high only at step 47, during soft-start
    for (int i = 1; i <= 50; i++) begin
      tick(1, (i == 47), 0);
      expect_bit(B_THR, 1, "R9");
      if (i == 47) expect_bit(B_TRIP, 0, "R12");
      if (i == 48) expect_bit(B_TRIP, 1, "R12");
    end
    for (int i = 1; i <= 4; i++) tick(0, 0, 0);
    // half of 50 = 25 forced steps
    for (int i = 1; i <= 60; i++) begin
      tick((i <= 30), 0, 0);
      if (i == 1 || i == 25) expect_bit(B_HS, 1, "R7");
      if (i == 26) begin
        expect_bit(B_HS, 0, "R8"); expect_bit(B_LS, 0, "R8");
      end
      if (i == 56) expect_bit(B_RS, 0, "R10");
      if (i == 57) expect_bit(B_RS, 1, "R10");
      if (i == 58) expect_bit(B_TRIP, 0, "R11");
    end

    tick(0, 0, 0);
    tick(0, 0, 0);
    @(negedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end
endmodule